// File: doc/BRIEF.md
# Indirect-access interrupt routing register file

This block is the software-visible register file of an interrupt router. Software reaches it over a small memory-mapped bus with three decoded offsets: a select register at 0x00, a 32-bit data window at 0x10 and an end-of-interrupt port at 0x40. Software first writes an index into the select register. It then reads or writes the indexed register through the window. The indexed space holds an identification register, a version register, an arbitration register and a routing table. The routing table has one 64-bit entry per interrupt pin, and each entry is reached as two 32-bit halves.

The table contents go out flat to the per-pin interrupt logic. That logic reports remote-IRR set and clear events back to the block through per-pin strobes. Writes to the table produce two single-cycle side-effect strobes: a service request, when a level-triggered pin is still pending, and a mask-change notice. A write to the end-of-interrupt port forwards its low byte as a vector to the acknowledge logic, and that acknowledge is always handled as a level-triggered one.

Entry layout: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-IRR 14 (read-only), trigger mode 15 (1 = level), mask 16, destination 63:56.

Top module: `irq_route_regs`

## Requirements
- R1: After reset the select register reads 0, the ID field reads 0, and every table entry reads 0x0000_0000_0001_0000 (mask bit 16 set, all other bits 0).
- R2: A write to offset 0x00 loads the 8-bit select register, and a read of 0x00 returns it in bits 7:0. Read data appears on bus_rdata in the cycle after the read request and holds until the next read.
- R3: Window index 0x01 reads as the pin count minus one in bits 23:16 and the VERSION parameter in bits 7:0. Window writes to index 0x01 change nothing.
- R4: Window index 0x00 holds a 4-bit ID in bits 27:24, which can be both written and read. Index 0x02 reads back the same ID, and writes to index 0x02 change nothing.
- R5: Window index 0x10 + 2n selects bits 31:0 of entry n, and index 0x11 + 2n selects bits 63:32 of entry n.
- R6: A write to the low half replaces bits 31:0 and forces remote-IRR (bit 14) to 0. A write to the high half replaces bits 63:32 and leaves bits 31:0 unchanged.
- R7: A window access whose entry number is not below the pin count, or whose index is unassigned, writes nothing and reads 0.
- R8: Bit 14 of entry n is set by rirr_set[n] and cleared by rirr_clr[n]. Software cannot set it. A low-half write in the same cycle as rirr_set takes precedence and leaves the bit at 0.
- R9: In the cycle after a write to either half of entry n, svc_req has bit n high exactly when the new entry has bit 15 set and pin_pending[n] is high. At all other times svc_req is 0.
- R10: When a write changes bit 16 of entry n, mchg_valid pulses for one cycle in the following cycle, with mchg_pin = n and mchg_mask equal to the new bit value. Otherwise mchg_valid stays low.
- R11: A write to offset 0x40 pulses eoi_valid for one cycle in the following cycle, with eoi_vector equal to wdata[7:0].
- R12: An access is ignored when bus_len is not 4 or 8, or when bus_addr[3:0] is nonzero. Such a write changes nothing, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDRW | Byte offset of the access |
| bus_len | input | 4 | Access length in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| pin_pending | input | NPINS | Pending level per pin |
| rirr_set | input | NPINS | Per-pin strobe that sets remote-IRR |
| rirr_clr | input | NPINS | Per-pin strobe that clears remote-IRR |
| entry_cfg | output | NPINS*64 | All table entries, entry n at bits 64n+63:64n |
| svc_req | output | NPINS | Per-pin service request pulse |
| mchg_valid | output | 1 | Mask-change pulse |
| mchg_pin | output | IDXW | Pin whose mask changed |
| mchg_mask | output | 1 | New mask value |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_vector | output | 8 | Acknowledged vector |

## Verification
The hardest situation to reach is a service request. It needs a level-triggered entry, a pending pin and a write to that same entry, with the select register already pointing at the entry. The stimulus biases the random window data toward bit 15 and redraws pin_pending before every operation, so writes to level-triggered entries often land on pending pins. A second hard case is a low-half write that coincides with a remote-IRR set strobe. The directed part of the bench drives that collision explicitly.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_ID,
        WK_VER,
        WK_ARB,
        WK_ENT
    } win_kind_e;

    localparam logic [7:0] OFS_SEL = 8'h00;
    localparam logic [7:0] OFS_WIN = 8'h10;
    localparam logic [7:0] OFS_EOI = 8'h40;

    localparam int unsigned IDX_ID  = 0;
    localparam int unsigned IDX_VER = 1;
    localparam int unsigned IDX_ARB = 2;
    localparam int unsigned IDX_TBL = 16;

    localparam int unsigned BIT_RIRR = 14;
    localparam int unsigned BIT_TRIG = 15;
    localparam int unsigned BIT_MASK = 16;

    localparam logic [63:0] ENT_RESET = 64'h0000_0000_0001_0000;

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int unsigned NPINS = 24,
    parameter int unsigned ADDRW = 8,
    parameter int unsigned SELW  = 8,
    localparam int unsigned IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             bus_valid,
    input  logic [ADDRW-1:0] bus_addr,
    input  logic [3:0]       bus_len,
    input  logic [SELW-1:0]  sel_q,
    output logic             acc_ok,
    output logic             hit_sel,
    output logic             hit_win,
    output logic             hit_eoi,
    output win_kind_e        win_kind,
    output logic [IDXW-1:0]  ent_idx,
    output logic             ent_hi
);

    logic [31:0] sel32;
    logic [31:0] ent_num;

    always_comb begin
        acc_ok  = bus_valid && (bus_len == 4'd4 || bus_len == 4'd8)
                  && (bus_addr[3:0] == 4'h0);
        hit_sel = acc_ok && (bus_addr == ADDRW'(OFS_SEL));
        hit_win = acc_ok && (bus_addr == ADDRW'(OFS_WIN));
        hit_eoi = acc_ok && (bus_addr == ADDRW'(OFS_EOI));

        sel32   = 32'(sel_q);
        ent_num = (sel32 >= IDX_TBL) ? ((sel32 - IDX_TBL) >> 1) : 32'd0;
        ent_idx = ent_num[IDXW-1:0];
        ent_hi  = sel_q[0];

        if (sel32 == IDX_ID) begin
            win_kind = WK_ID;
        end else if (sel32 == IDX_VER) begin
            win_kind = WK_VER;
        end else if (sel32 == IDX_ARB) begin
            win_kind = WK_ARB;
        end else if (sel32 >= IDX_TBL && ent_num < NPINS) begin
            win_kind = WK_ENT;
        end else begin
            win_kind = WK_NONE;
        end
    end

endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
    import irq_route_pkg::*;
#(
    parameter int unsigned NPINS   = 24,
    parameter logic [7:0]  VERSION = 8'h11,
    localparam int unsigned IDXW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  win_kind_e                  win_kind,
    input  logic [IDXW-1:0]            ent_idx,
    input  logic                       ent_hi,
    input  logic [3:0]                 id_q,
    input  logic [NPINS-1:0][63:0]     entries,
    output logic [31:0]                win_data
);

    localparam logic [7:0] MAXPIN = 8'(NPINS - 1);

    logic [63:0] sel_ent;

    always_comb begin
        sel_ent = entries[ent_idx];
        unique case (win_kind)
            WK_VER:        win_data = {8'h00, MAXPIN, 8'h00, VERSION};
            WK_ID, WK_ARB: win_data = {4'h0, id_q, 24'h0};
            WK_ENT:        win_data = ent_hi ? sel_ent[63:32] : sel_ent[31:0];
            default:       win_data = 32'h0;
        endcase
    end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int unsigned NPINS = 24,
    localparam int unsigned IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_hi,
    input  logic [IDXW-1:0]        wr_idx,
    input  logic [31:0]            wr_data,
    input  logic [NPINS-1:0]       pin_pending,
    input  logic [NPINS-1:0]       rirr_set,
    input  logic [NPINS-1:0]       rirr_clr,
    output logic [NPINS-1:0][63:0] entries,
    output logic [NPINS-1:0]       svc_req,
    output logic                   mchg_valid,
    output logic [IDXW-1:0]        mchg_pin,
    output logic                   mchg_mask
);

    typedef struct packed {
        logic [NPINS-1:0][63:0] ent;
        logic [NPINS-1:0]       svc;
        logic                   mv;
        logic [IDXW-1:0]        mp;
        logic                   mm;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [NPINS-1:0] rirr_nxt;
    logic [63:0]      old_ent;
    logic [63:0]      new_ent;

    // Per-pin remote-IRR update from the pin logic strobes
    for (genvar g = 0; g < NPINS; g++) begin : g_rirr
        always_comb begin
            if (rirr_set[g]) begin
                rirr_nxt[g] = 1'b1;
            end else if (rirr_clr[g]) begin
                rirr_nxt[g] = 1'b0;
            end else begin
                rirr_nxt[g] = tbl_q.ent[g][BIT_RIRR];
            end
        end
    end

    always_comb begin
        tbl_d     = tbl_q;
        tbl_d.svc = '0;
        tbl_d.mv  = 1'b0;
        for (int i = 0; i < NPINS; i++) begin
            tbl_d.ent[i][BIT_RIRR] = rirr_nxt[i];
        end
        old_ent = tbl_d.ent[wr_idx];
        new_ent = old_ent;
        if (wr_en) begin
            if (wr_hi) begin
                new_ent[63:32] = wr_data;
            end else begin
                new_ent[31:0]     = wr_data;
                new_ent[BIT_RIRR] = 1'b0;
            end
            tbl_d.ent[wr_idx] = new_ent;
            if (new_ent[BIT_MASK] != old_ent[BIT_MASK]) begin
                tbl_d.mv = 1'b1;
                tbl_d.mp = wr_idx;
                tbl_d.mm = new_ent[BIT_MASK];
            end
            if (new_ent[BIT_TRIG] && pin_pending[wr_idx]) begin
                tbl_d.svc[wr_idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPINS; i++) begin
                tbl_q.ent[i] <= ENT_RESET;
            end
            tbl_q.svc <= '0;
            tbl_q.mv  <= 1'b0;
            tbl_q.mp  <= '0;
            tbl_q.mm  <= 1'b0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign entries    = tbl_q.ent;
    assign svc_req    = tbl_q.svc;
    assign mchg_valid = tbl_q.mv;
    assign mchg_pin   = tbl_q.mp;
    assign mchg_mask  = tbl_q.mm;

    // R6 / R8: a low-half write leaves remote-IRR cleared, even against a set strobe
    a_r6_lo_clears_rirr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> (entries[$past(wr_idx)][BIT_RIRR] == 1'b0));

    // R9: at most one pin is serviced per cycle
    a_r9_svc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc_req));

    // R9: a service request follows only a table write
    a_r9_svc_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req != '0) |-> $past(wr_en));

    // R10: the reported mask value matches the stored entry
    a_r10_mchg_matches: assert property (@(posedge clk) disable iff (!rst_n)
        mchg_valid |-> (entries[mchg_pin][BIT_MASK] == mchg_mask));

    // R10: a mask-change notice follows only a table write
    a_r10_mchg_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mchg_valid |-> $past(wr_en));

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned NPINS   = 24,
    parameter int unsigned ADDRW   = 8,
    parameter logic [7:0]  VERSION = 8'h11,
    localparam int unsigned IDXW   = (NPINS > 1) ? $clog2(NPINS) : 1,
    localparam int unsigned SELW   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDRW-1:0]      bus_addr,
    input  logic [3:0]            bus_len,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NPINS-1:0]      pin_pending,
    input  logic [NPINS-1:0]      rirr_set,
    input  logic [NPINS-1:0]      rirr_clr,
    output logic [NPINS*64-1:0]   entry_cfg,
    output logic [NPINS-1:0]      svc_req,
    output logic                  mchg_valid,
    output logic [IDXW-1:0]       mchg_pin,
    output logic                  mchg_mask,
    output logic                  eoi_valid,
    output logic [7:0]            eoi_vector
);

    typedef struct packed {
        logic [SELW-1:0] sel;
        logic [3:0]      id;
        logic [31:0]     rdata;
        logic            eoi_v;
        logic [7:0]      eoi_vec;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             acc_ok;
    logic             hit_sel;
    logic             hit_win;
    logic             hit_eoi;
    win_kind_e        win_kind;
    logic [IDXW-1:0]  ent_idx;
    logic             ent_hi;
    logic [31:0]      win_data;
    logic             tbl_wr;
    logic [NPINS-1:0][63:0] entries;

    irq_route_decode #(.NPINS(NPINS), .ADDRW(ADDRW), .SELW(SELW)) u_dec (
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_len   (bus_len),
        .sel_q     (regs_q.sel),
        .acc_ok    (acc_ok),
        .hit_sel   (hit_sel),
        .hit_win   (hit_win),
        .hit_eoi   (hit_eoi),
        .win_kind  (win_kind),
        .ent_idx   (ent_idx),
        .ent_hi    (ent_hi)
    );

    irq_route_rdmux #(.NPINS(NPINS), .VERSION(VERSION)) u_rd (
        .win_kind (win_kind),
        .ent_idx  (ent_idx),
        .ent_hi   (ent_hi),
        .id_q     (regs_q.id),
        .entries  (entries),
        .win_data (win_data)
    );

    assign tbl_wr = hit_win && bus_write && (win_kind == WK_ENT);

    irq_route_table #(.NPINS(NPINS)) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (tbl_wr),
        .wr_hi       (ent_hi),
        .wr_idx      (ent_idx),
        .wr_data     (bus_wdata),
        .pin_pending (pin_pending),
        .rirr_set    (rirr_set),
        .rirr_clr    (rirr_clr),
        .entries     (entries),
        .svc_req     (svc_req),
        .mchg_valid  (mchg_valid),
        .mchg_pin    (mchg_pin),
        .mchg_mask   (mchg_mask)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.eoi_v = 1'b0;
        if (bus_write) begin
            if (hit_sel) begin
                regs_d.sel = bus_wdata[SELW-1:0];
            end
            if (hit_win && win_kind == WK_ID) begin
                regs_d.id = bus_wdata[27:24];
            end
            if (hit_eoi) begin
                regs_d.eoi_v   = 1'b1;
                regs_d.eoi_vec = bus_wdata[7:0];
            end
        end else if (bus_valid) begin
            if (hit_sel) begin
                regs_d.rdata = 32'(regs_q.sel);
            end else if (hit_win) begin
                regs_d.rdata = win_data;
            end else begin
                regs_d.rdata = 32'h0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_rdata  = regs_q.rdata;
    assign eoi_valid  = regs_q.eoi_v;
    assign eoi_vector = regs_q.eoi_vec;
    assign entry_cfg  = entries;

    // R11: an acknowledge pulse follows a write to the acknowledge offset
    a_r11_eoi_source: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(bus_valid && bus_write && bus_addr == ADDRW'(OFS_EOI)));

    // R11: the forwarded vector is the written low byte
    a_r11_eoi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> (eoi_vector == $past(bus_wdata[7:0])));

    // R2: read data changes only after a read request
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_valid && !bus_write) |-> $stable(bus_rdata));

    // R12: a request of an unsupported length leaves the select register alone
    a_r12_bad_len_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_len != 4'd4 && bus_len != 4'd8) |=> $stable(regs_q.sel));

endmodule

// File: tb/irq_route_regs_test.sv
module irq_route_regs_test;

    localparam int unsigned NPINS = 24;
    localparam int unsigned IDXW  = 5;
    localparam logic [7:0]  VER   = 8'h11;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_valid = 1'b0;
    logic                bus_write = 1'b0;
    logic [7:0]          bus_addr = '0;
    logic [3:0]          bus_len = 4'd4;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [NPINS-1:0]    pin_pending = '0;
    logic [NPINS-1:0]    rirr_set = '0;
    logic [NPINS-1:0]    rirr_clr = '0;
    logic [NPINS*64-1:0] entry_cfg;
    logic [NPINS-1:0]    svc_req;
    logic                mchg_valid;
    logic [IDXW-1:0]     mchg_pin;
    logic                mchg_mask;
    logic                eoi_valid;
    logic [7:0]          eoi_vector;

    always #2 clk = ~clk;

    irq_route_regs #(.NPINS(NPINS), .ADDRW(8), .VERSION(VER)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_pending(pin_pending), .rirr_set(rirr_set),
        .rirr_clr(rirr_clr), .entry_cfg(entry_cfg), .svc_req(svc_req),
        .mchg_valid(mchg_valid), .mchg_pin(mchg_pin), .mchg_mask(mchg_mask),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_ent [NPINS];
    logic [3:0]  m_id;
    logic [7:0]  m_sel;

    logic [31:0]      ob_rdata;
    logic [NPINS-1:0] ob_svc;
    logic             ob_mv;
    logic [IDXW-1:0]  ob_mp;
    logic             ob_mm;
    logic             ob_ev;
    logic [7:0]       ob_evec;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input bit wr, input logic [7:0] addr, input logic [31:0] data,
                          input logic [3:0] len);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_wdata = data; bus_len = len;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        rirr_set = '0; rirr_clr = '0;
        ob_rdata = bus_rdata; ob_svc = svc_req; ob_mv = mchg_valid;
        ob_mp = mchg_pin; ob_mm = mchg_mask; ob_ev = eoi_valid; ob_evec = eoi_vector;
    endtask

    function automatic bit ent_of(input logic [7:0] sel, output int n);
        n = (int'(sel) - 16) >>> 1;
        return (sel >= 8'h10) && (n < NPINS);
    endfunction

    function automatic logic [31:0] exp_win(input logic [7:0] sel);
        int n;
        if (sel == 8'h00 || sel == 8'h02) return {4'h0, m_id, 24'h0};
        if (sel == 8'h01) return {8'h00, 8'(NPINS - 1), 8'h00, VER};
        if (ent_of(sel, n)) return sel[0] ? m_ent[n][63:32] : m_ent[n][31:0];
        return 32'h0;
    endfunction

    task automatic set_sel(input logic [7:0] s);
        bus_op(1'b1, 8'h00, {24'h0, s}, 4'd4);
        m_sel = s;
    endtask

    task automatic win_read(input string req);
        logic [31:0] e;
        e = exp_win(m_sel);
        bus_op(1'b0, 8'h10, 32'h0, 4'd4);
        chk(ob_rdata == e, req, 64'(ob_rdata), 64'(e));
    endtask

    // window write with model update and strobe checks
    task automatic win_write(input logic [31:0] d, input logic [3:0] len);
        int n;
        logic [63:0] old, nw;
        bit exp_mv, hit;
        logic [NPINS-1:0] exp_svc;
        exp_svc = '0; exp_mv = 0; nw = '0;
        hit = ent_of(m_sel, n);
        if (m_sel == 8'h00) m_id = d[27:24];
        if (hit) begin
            old = m_ent[n]; nw = old;
            if (m_sel[0]) nw[63:32] = d;
            else begin nw[31:0] = d; nw[14] = 1'b0; end
            exp_mv = (nw[16] != old[16]);
            if (nw[15] && pin_pending[n]) exp_svc[n] = 1'b1;
            m_ent[n] = nw;
        end
        bus_op(1'b1, 8'h10, d, len);
        chk(ob_svc == exp_svc, "R9 svc_req", 64'(ob_svc), 64'(exp_svc));
        chk(ob_mv == exp_mv, "R10 mchg_valid", 64'(ob_mv), 64'(exp_mv));
        if (exp_mv) begin
            chk(ob_mp == IDXW'(n) && ob_mm == nw[16], "R10 mchg pin/mask",
                64'({ob_mp, ob_mm}), 64'({IDXW'(n), nw[16]}));
        end
        chk(!ob_ev, "R11 no eoi on window write", 64'(ob_ev), 64'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NPINS; i++) m_ent[i] = 64'h0000_0000_0001_0000;
        m_id = 4'h0; m_sel = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_op(1'b0, 8'h00, 32'h0, 4'd4);
        chk(ob_rdata == 32'h0, "R1 select after reset", 64'(ob_rdata), 64'(0));
        win_read("R1 id after reset");
        for (int i = 0; i < NPINS; i++) begin
            chk(entry_cfg[i*64 +: 64] == 64'h1_0000, "R1 entry reset",
                entry_cfg[i*64 +: 64], 64'h1_0000);
        end

        // R3: version read, write ignored
        set_sel(8'h01);
        win_read("R3 version");
        win_write(32'hFFFF_FFFF, 4'd4);
        win_read("R3 version after write");

        // R4: id and arbitration
        set_sel(8'h00);
        win_write(32'hA500_0000, 4'd4);
        win_read("R4 id readback");
        set_sel(8'h02);
        win_read("R4 arb mirrors id");
        win_write(32'h3000_0000, 4'd4);
        set_sel(8'h00);
        win_read("R4 arb write ignored");

        // R2: select readback
        set_sel(8'h27);
        bus_op(1'b0, 8'h00, 32'h0, 4'd8);
        chk(ob_rdata == 32'h27, "R2 select readback", 64'(ob_rdata), 64'h27);

        // R5 / R6: halves of entry 5
        set_sel(8'h1A);
        win_write(32'h0000_80C3, 4'd4);
        set_sel(8'h1B);
        win_write(32'hFE00_0000, 4'd8);
        chk(entry_cfg[5*64 +: 64] == 64'hFE00_0000_0000_80C3, "R5 entry 5 layout",
            entry_cfg[5*64 +: 64], 64'hFE00_0000_0000_80C3);
        set_sel(8'h1A);
        win_read("R6 low half kept after high write");

        // R8: remote-IRR set and software cannot set it
        rirr_set[5] = 1'b1;
        bus_op(1'b0, 8'h10, 32'h0, 4'd4);
        m_ent[5][14] = 1'b1;
        win_read("R8 rirr set by strobe");
        set_sel(8'h1B);
        win_write(32'h1100_0000, 4'd4);
        chk(entry_cfg[5*64 + 14] == 1'b1, "R6 high write keeps rirr",
            64'(entry_cfg[5*64 + 14]), 64'(1));
        rirr_clr[5] = 1'b1;
        bus_op(1'b0, 8'h00, 32'h0, 4'd4);
        m_ent[5][14] = 1'b0;
        chk(entry_cfg[5*64 + 14] == 1'b0, "R8 rirr cleared by strobe",
            64'(entry_cfg[5*64 + 14]), 64'(0));
        set_sel(8'h1A);
        rirr_set[5] = 1'b1;
        win_write(32'h0000_40C3, 4'd4);
        chk(entry_cfg[5*64 + 14] == 1'b0, "R8 low write beats set strobe",
            64'(entry_cfg[5*64 + 14]), 64'(0));

        // R9: level-triggered pending pin
        pin_pending = '0; pin_pending[5] = 1'b1;
        win_write(32'h0000_8033, 4'd4);
        pin_pending = '0;
        win_write(32'h0000_8033, 4'd4);

        // R10: unmask entry 0 then mask again
        set_sel(8'h10);
        win_write(32'h0000_0020, 4'd4);
        win_write(32'h0001_0020, 4'd4);

        // R7: out of range and unassigned indices
        set_sel(8'h40);
        win_write(32'hDEAD_BEEF, 4'd4);
        win_read("R7 out-of-range read");
        set_sel(8'h05);
        win_read("R7 unassigned read");

        // R11: end of interrupt
        bus_op(1'b1, 8'h40, 32'h1234_56A7, 4'd4);
        chk(ob_ev == 1'b1 && ob_evec == 8'hA7, "R11 eoi pulse",
            64'({ob_ev, ob_evec}), 64'({1'b1, 8'hA7}));
        bus_op(1'b0, 8'h00, 32'h0, 4'd4);
        chk(ob_ev == 1'b0, "R11 eoi single pulse", 64'(ob_ev), 64'(0));

        // R12: bad length and misalignment
        bus_op(1'b1, 8'h00, 32'h0000_0011, 4'd2);
        bus_op(1'b0, 8'h00, 32'h0, 4'd4);
        chk(ob_rdata == 32'h05, "R12 bad length write ignored", 64'(ob_rdata), 64'h05);
        bus_op(1'b0, 8'h00, 32'h0, 4'd1);
        chk(ob_rdata == 32'h0, "R12 bad length read zero", 64'(ob_rdata), 64'(0));
        bus_op(1'b1, 8'h04, 32'h0000_0013, 4'd4);
        bus_op(1'b0, 8'h04, 32'h0, 4'd4);
        chk(ob_rdata == 32'h0, "R12 misaligned read zero", 64'(ob_rdata), 64'(0));
        bus_op(1'b0, 8'h00, 32'h0, 4'd4);
        chk(ob_rdata == 32'h05, "R12 misaligned write ignored", 64'(ob_rdata), 64'h05);

        // random phase
        for (int k = 0; k < 1500; k++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom % 10);
            pin_pending = NPINS'($urandom);
            if (op < 2) begin
                set_sel(8'($urandom % 8'h44));
            end else if (op < 6) begin
                d = $urandom;
                if ($urandom % 2 == 0) d[15] = 1'b1;
                if ($urandom % 3 == 0) d[16] = ~d[16];
                win_write(d, ($urandom % 2 == 0) ? 4'd4 : 4'd8);
            end else if (op < 9) begin
                win_read("R5 random window read");
            end else begin
                bus_op(1'b0, 8'h00, 32'h0, 4'd4);
                chk(ob_rdata == 32'(m_sel), "R2 random select read", 64'(ob_rdata), 64'(m_sel));
            end
        end

        for (int i = 0; i < NPINS; i++) begin
            chk(entry_cfg[i*64 +: 64] == m_ent[i], "R6 final entry image",
                entry_cfg[i*64 +: 64], m_ent[i]);
        end
        n = 0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule